// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block lets a CPU reach PCI configuration space indirectly. Software first writes a target selector into a 32-bit configuration address register. It then reads or writes a 32-bit data window, and each enabled window access becomes one request on a generic configuration-access interface. That interface carries an address, a write flag, write data, returned read data and a ready handshake. A PCI command register sits next to the pair, and its low bit sets the byte order of data passing through the window.

The CPU side is a simple word-addressed register bus. The master raises `bus_req_i` with address, write flag and data, and holds all of them until `bus_ack_o` pulses for one cycle. Register accesses acknowledge after one cycle. A data-window access that reaches the configuration interface acknowledges only after the ready response. When the enable bit in the address register is clear, the window answers locally: reads return all ones and writes are discarded.

Byte reversal applies when the command swap bit is 0 and the selected bus/device field is nonzero. The bridge's own function (bus 0, device 0) is never reversed. The swap decision is taken from the current register contents at each access, so a change takes effect on the next access.

Top module: `pci_cfg_port`

## Requirements
- R1: A write to the configuration address register (byte address 0x0F8, word index 0x03E) stores the data ANDed with 0x80fffffc. A read of that register returns the stored value.
- R2: A write to the command register (byte address 0xC00, word index 0x300) stores the data ANDed with 0x0401fc0f. A read returns the stored value.
- R3: When address bit 31 is 0, a read of the data window (byte address 0x0FC, word index 0x03F) returns 0xffffffff and raises no configuration request.
- R4: When address bit 31 is 0, a write to the data window is discarded and raises no configuration request.
- R5: When address bit 31 is 1, a data-window access raises `cfg_req_o` for exactly one cycle, with `cfg_addr_o` equal to the stored address and `cfg_we_o` equal to the access direction. `bus_ack_o` pulses only after `cfg_rdy_i` has been seen.
- R6: With command bit 0 equal to 0 and address bits 23:11 nonzero, write data and returned read data are byte-reversed: byte 3 trades places with byte 0, and byte 2 with byte 1.
- R7: With address bits 23:11 all zero, data passes unreversed whatever the command register holds, including for nonzero function/register bits 10:2.
- R8: With command bit 0 equal to 1, data passes unreversed.
- R9: A change to command bit 0 governs the very next data-window access.
- R10: After reset, the address and command registers read as zero, and a data-window read returns 0xffffffff.
- R11: The word index is the byte address shifted right by two. A read of any other word index returns zero, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | CPU access request, held until acknowledged |
| bus_we_i | input | 1 | CPU access is a write |
| bus_addr_i | input | ADDR_W | CPU byte address |
| bus_wdata_i | input | 32 | CPU write data |
| bus_rdata_o | output | 32 | CPU read data, valid with acknowledge |
| bus_ack_o | output | 1 | One-cycle access completion |
| cfg_req_o | output | 1 | One-cycle configuration request |
| cfg_we_o | output | 1 | Configuration request is a write |
| cfg_addr_o | output | 32 | Configuration address with enable in bit 31 |
| cfg_wdata_o | output | 32 | Configuration write data after byte ordering |
| cfg_rdata_i | input | 32 | Configuration read data |
| cfg_rdy_i | input | 1 | Configuration access completed |

## Verification
The bench drives the swap boundary from both sides. One case has a function number set but device and bus zero, which must stay unreversed. Another has a device of one, which must reverse. A design that tested the wrong bit range would swap the bridge's own header or leave peripherals garbled. The bench toggles the command bit between back-to-back window accesses to catch a stale byte order. It counts configuration requests across disabled accesses, so a design that leaked a request or returned zero instead of all ones is caught. It writes all-ones patterns to both registers to expose a wrong mask.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_ACK
  } seq_st_e;

  localparam logic [31:0] ADDR_KEEP = 32'h80fffffc;
  localparam logic [31:0] CMD_KEEP  = 32'h0401fc0f;
  localparam logic [31:0] ALL_ONES  = 32'hffffffff;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned SEL_LO    = 11;
  localparam int unsigned SEL_HI    = 23;
endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_ADDR = 10'h03e,
  parameter int unsigned IDX_DATA = 10'h03f,
  parameter int unsigned IDX_CMD  = 10'h300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              hit_data_o,
  output logic              enable_o,
  output logic              swap_en_o,
  output logic [31:0]       rdata_o,
  output logic [31:0]       cfg_addr_o
);
  import pcfg_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit_addr, hit_cmd;
  logic [31:0]      addr_q, cmd_q;

  assign idx        = addr_i[ADDR_W-1:2];
  assign hit_addr   = (idx == IDX_W'(IDX_ADDR));
  assign hit_cmd    = (idx == IDX_W'(IDX_CMD));
  assign hit_data_o = (idx == IDX_W'(IDX_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (acc_i && we_i) begin
      if (hit_addr) addr_q <= wdata_i & ADDR_KEEP;
      if (hit_cmd)  cmd_q  <= wdata_i & CMD_KEEP;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_addr)     rdata_o = addr_q;
    else if (hit_cmd) rdata_o = cmd_q;
  end

  // swap only toward peripherals, never the bridge's own header
  assign swap_en_o  = !cmd_q[0] && (|addr_q[SEL_HI:SEL_LO]);
  assign enable_o   = addr_q[EN_BIT];
  assign cfg_addr_o = addr_q;

  p_addr_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && we_i && hit_addr) |=> $stable(addr_q));

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && we_i && hit_cmd) |=> $stable(cmd_q));
endmodule

// File: rtl/pcfg_swap.sv
module pcfg_swap #(
  parameter int unsigned BYTES = 4
) (
  input  logic               swap_en_i,
  input  logic [8*BYTES-1:0] d_i,
  output logic [8*BYTES-1:0] d_o
);
  logic [8*BYTES-1:0] rev;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign rev[8*b +: 8] = d_i[8*(BYTES-1-b) +: 8];
  end

  assign d_o = swap_en_i ? rev : d_i;
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [31:0] bus_wdata_i,
  input  logic        hit_data_i,
  input  logic        enable_i,
  input  logic [31:0] reg_rdata_i,
  input  logic [31:0] cfg_rdata_i,
  input  logic        cfg_rdy_i,
  output logic        acc_o,
  output logic        cfg_req_o,
  output logic        cfg_we_o,
  output logic [31:0] wdata_o,
  output logic        bus_ack_o,
  output logic [31:0] bus_rdata_o
);
  import pcfg_pkg::*;

  seq_st_e     st_q;
  logic        we_q;
  logic [31:0] wdata_q, rdata_q;

  assign acc_o = (st_q == ST_IDLE) && bus_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (bus_req_i) begin
          we_q    <= bus_we_i;
          wdata_q <= bus_wdata_i;
          if (hit_data_i && enable_i) begin
            st_q <= ST_ISSUE;
          end else begin
            rdata_q <= hit_data_i ? ALL_ONES : reg_rdata_i;
            st_q    <= ST_ACK;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (cfg_rdy_i) begin
          rdata_q <= we_q ? '0 : cfg_rdata_i;
          st_q    <= ST_ACK;
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req_o   = (st_q == ST_ISSUE);
  assign cfg_we_o    = we_q;
  assign wdata_o     = wdata_q;
  assign bus_ack_o   = (st_q == ST_ACK);
  assign bus_rdata_o = rdata_q;

  p_req_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);

  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);

  p_no_early_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !cfg_rdy_i) |=> !bus_ack_o);

  p_req_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> enable_i);

  p_dis_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && hit_data_i && !enable_i) |=> !cfg_req_o);
endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_ADDR = 10'h03e,
  parameter int unsigned IDX_DATA = 10'h03f,
  parameter int unsigned IDX_CMD  = 10'h300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_ack_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [31:0]       cfg_addr_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic [31:0]       cfg_rdata_i,
  input  logic              cfg_rdy_i
);
  logic        acc, hit_data, enable, swap_en;
  logic [31:0] reg_rdata, wdata_raw, rdata_sw;

  pcfg_regs #(
    .ADDR_W  (ADDR_W),
    .IDX_ADDR(IDX_ADDR),
    .IDX_DATA(IDX_DATA),
    .IDX_CMD (IDX_CMD)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .hit_data_o(hit_data),
    .enable_o  (enable),
    .swap_en_o (swap_en),
    .rdata_o   (reg_rdata),
    .cfg_addr_o(cfg_addr_o)
  );

  pcfg_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .hit_data_i (hit_data),
    .enable_i   (enable),
    .reg_rdata_i(reg_rdata),
    .cfg_rdata_i(rdata_sw),
    .cfg_rdy_i  (cfg_rdy_i),
    .acc_o      (acc),
    .cfg_req_o  (cfg_req_o),
    .cfg_we_o   (cfg_we_o),
    .wdata_o    (wdata_raw),
    .bus_ack_o  (bus_ack_o),
    .bus_rdata_o(bus_rdata_o)
  );

  // registers cannot change mid-access, so the live decision is current
  pcfg_swap #(.BYTES(4)) u_swap_wr (
    .swap_en_i(swap_en),
    .d_i      (wdata_raw),
    .d_o      (cfg_wdata_o)
  );

  pcfg_swap #(.BYTES(4)) u_swap_rd (
    .swap_en_i(swap_en),
    .d_i      (cfg_rdata_i),
    .d_o      (rdata_sw)
  );
endmodule

// File: tb/pci_cfg_port_bench.sv
module pci_cfg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ADDR = 12'h0f8;
  localparam logic [11:0] A_DATA = 12'h0fc;
  localparam logic [11:0] A_CMD  = 12'hc00;

  typedef struct {
    bit          rd;
    logic [31:0] exp;
    string       tag;
  } bus_item_t;

  typedef struct {
    logic [31:0] addr;
    bit          we;
    logic [31:0] wdata;
    logic [31:0] resp;
    string       tag;
  } cfg_item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, cfg_rdata = '0;
  logic        cfg_rdy = 1'b0;
  logic [31:0] rdata, cfg_addr, cfg_wdata;
  logic        ack, cfg_req, cfg_we;

  int total = 0, bad = 0, cfg_cnt = 0;
  bus_item_t bus_q[$];
  cfg_item_t cfg_q[$];
  bus_item_t bi;
  cfg_item_t ci;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_port u_pci_cfg_port (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_ack_o(ack),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata), .cfg_rdy_i(cfg_rdy)
  );

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [11:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
    bus_item_t it;
    it.rd = !w; it.exp = exp; it.tag = tag;
    bus_q.push_back(it);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    req = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_cfg(input logic [31:0] a, input bit w, input logic [31:0] wd,
                            input logic [31:0] resp, input string tag);
    cfg_item_t it;
    it.addr = a; it.we = w; it.wdata = wd; it.resp = resp; it.tag = tag;
    cfg_q.push_back(it);
  endtask

  // bus monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (bus_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5: unexpected ack actual=1 expected=0");
      end else begin
        bi = bus_q.pop_front();
        if (bi.rd) chk(bi.tag, rdata, bi.exp);
      end
    end
  end

  // configuration responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cfg_req) begin
        cfg_cnt++;
        if (cfg_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R3/R4 leak: cfg_req actual=1 expected=0");
          ci.resp = '0; ci.tag = "leak";
        end else begin
          ci = cfg_q.pop_front();
          chk({ci.tag, " addr"}, cfg_addr, ci.addr);
          chk({ci.tag, " we"}, {31'b0, cfg_we}, {31'b0, ci.we});
          if (ci.we) chk({ci.tag, " wdata"}, cfg_wdata, ci.wdata);
        end
        @(negedge clk);
        if (ack) begin
          total++; bad++;
          $display("FAIL R5: ack before ready actual=1 expected=0");
        end
        cfg_rdy = 1'b1; cfg_rdata = ci.resp;
        @(negedge clk);
        cfg_rdy = 1'b0; cfg_rdata = '0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    access(0, A_ADDR, '0, 32'h0, "R10 addr reset");
    access(0, A_CMD,  '0, 32'h0, "R10 cmd reset");
    c0 = cfg_cnt;
    access(0, A_DATA, '0, 32'hffffffff, "R10 window reset");
    chk("R3 no req after reset read", cfg_cnt, c0);

    // R1 masking
    access(1, A_ADDR, 32'hffffffff, '0, "R1 wr");
    access(0, A_ADDR, '0, 32'h80fffffc, "R1 mask ones");
    access(1, A_ADDR, 32'h7f000003, '0, "R1 wr");
    access(0, A_ADDR, '0, 32'h00000000, "R1 mask dropped bits");
    // R2 masking
    access(1, A_CMD, 32'hffffffff, '0, "R2 wr");
    access(0, A_CMD, '0, 32'h0401fc0f, "R2 mask ones");
    access(1, A_CMD, 32'h0, '0, "R2 clr");
    // R11 unmapped
    access(1, 12'h010, 32'h12345678, '0, "R11 wr");
    access(0, 12'h010, '0, 32'h0, "R11 unmapped read");
    access(0, A_ADDR, '0, 32'h0, "R11 addr untouched");
    access(0, A_CMD,  '0, 32'h0, "R11 cmd untouched");

    // R3/R4 disabled window (enable clear, selector nonzero)
    access(1, A_ADDR, 32'h00010800, '0, "R3 set");
    c0 = cfg_cnt;
    access(0, A_DATA, '0, 32'hffffffff, "R3 disabled read");
    access(1, A_DATA, 32'hdeadbeef, '0, "R4 disabled write");
    chk("R4 no cfg request", cfg_cnt, c0);

    // R6 swap, device 1 on bus 0
    access(1, A_ADDR, 32'h80000800, '0, "R6 set");
    expect_cfg(32'h80000800, 1, rev(32'h11223344), '0, "R6 wr");
    access(1, A_DATA, 32'h11223344, '0, "R6 wr");
    expect_cfg(32'h80000800, 0, '0, 32'ha1b2c3d4, "R6 rd");
    access(0, A_DATA, '0, rev(32'ha1b2c3d4), "R6 read swapped");
    chk("R5 one req per access", cfg_cnt, c0 + 2);

    // R7 bridge itself, function/register bits set
    access(1, A_ADDR, 32'h800007fc, '0, "R7 set");
    expect_cfg(32'h800007fc, 1, 32'hcafe0001, '0, "R7 wr");
    access(1, A_DATA, 32'hcafe0001, '0, "R7 wr");
    expect_cfg(32'h800007fc, 0, '0, 32'h01020304, "R7 rd");
    access(0, A_DATA, '0, 32'h01020304, "R7 read unswapped");

    // R8 swap bit set, bus nonzero
    access(1, A_CMD, 32'h1, '0, "R8 cmd");
    access(1, A_ADDR, 32'h80ff0000, '0, "R8 set");
    expect_cfg(32'h80ff0000, 1, 32'h55667788, '0, "R8 wr");
    access(1, A_DATA, 32'h55667788, '0, "R8 wr");
    expect_cfg(32'h80ff0000, 0, '0, 32'h9abcdef0, "R8 rd");
    access(0, A_DATA, '0, 32'h9abcdef0, "R8 read unswapped");

    // R9 toggle between back-to-back accesses
    access(1, A_CMD, 32'h0, '0, "R9 cmd clr");
    expect_cfg(32'h80ff0000, 0, '0, 32'h0badf00d, "R9 rd");
    access(0, A_DATA, '0, rev(32'h0badf00d), "R9 next read swapped");
    access(1, A_CMD, 32'h1, '0, "R9 cmd set");
    expect_cfg(32'h80ff0000, 1, 32'hfeedface, '0, "R9 wr");
    access(1, A_DATA, 32'hfeedface, '0, "R9 next write unswapped");

    repeat (4) @(negedge clk);
    chk("R5 scoreboard drained", bus_q.size() + cfg_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule